// File: doc/BRIEF.md
# Packed SIMD Saturating ALU

This block is a lane-parallel integer ALU for 64-bit words. A size select splits each operand into eight 8-bit, four 16-bit or two 32-bit lanes. The block then applies one operation to every lane at once. The operations are add and subtract in three overflow modes (wrap, signed clamp, unsigned clamp), per-lane shifts, and equality and signed greater-than compares that return full-lane masks. It also offers bitwise logic on the whole word, signed 16-bit multiplies, a pairwise multiply-accumulate, and a saturating narrow that merges two operands into one word.

A caller presents both operands, the opcode, the size select and a shift count with `in_valid` high. The result appears on `res` one clock later, with `res_valid` raised for that one cycle. Cycles without `in_valid` leave `res` unchanged, so a consumer may sample it at leisure.

Top module: `simd_sat_alu`

## Requirements
- R1: After reset, `res` is zero and `res_valid` is low. An operation presented with `in_valid` high appears on `res` at the next rising clock edge, and `res_valid` is high for exactly that cycle. When `in_valid` is low, `res` keeps its value and `res_valid` goes low on the next edge.
- R2: `lane_sz` selects the lane width: 0 gives 8 bits, 1 gives 16 bits, and 2 or 3 give 32 bits. Lane 0 occupies the least significant bits. Opcode 0 is a wrapping add and opcode 3 is a wrapping subtract, both modulo the lane width. No carry or borrow crosses a lane boundary.
- R3: Opcode 1 (add) and opcode 4 (subtract) treat lanes as two's-complement numbers. A result above the lane maximum is clamped to the maximum, and a result below the lane minimum is clamped to the minimum.
- R4: Opcode 2 (add) and opcode 5 (subtract) treat lanes as unsigned numbers. An add that overflows gives all ones, and a subtract that goes below zero gives zero.
- R5: The bitwise opcodes act on the whole word and ignore `lane_sz`. Opcode 6 gives a AND b, opcode 7 gives (NOT a) AND b, opcode 8 gives a OR b, and opcode 9 gives a XOR b.
- R6: The shift opcodes shift each lane of `op_a` by `shamt`. Opcode 10 is a logical left shift, opcode 11 is a logical right shift, and opcode 12 is an arithmetic right shift.
- R7: A `shamt` equal to or above the lane width gives a zero lane for opcodes 10 and 11. For opcode 12 it fills the lane with copies of its sign bit.
- R8: Opcode 13 (equal) and opcode 14 (signed a greater than b) set each lane to all ones when the test holds and to all zeros when it does not.
- R9: Opcodes 15 and 16 multiply the four 16-bit lanes pairwise as signed numbers. Opcode 15 returns the low 16 bits of each 32-bit product and opcode 16 returns the high 16 bits. `lane_sz` is ignored.
- R10: Opcode 17 forms the four signed 16x16 products and adds each adjacent pair (lanes 0+1 and lanes 2+3). The two sums are returned as two 32-bit lanes, wrapping modulo 2^32. `lane_sz` is ignored.
- R11: Opcode 18 narrows with signed saturation. With `lane_sz` 1, 16-bit lanes become 8-bit lanes. With `lane_sz` 2, 32-bit lanes become 16-bit lanes. The narrowed lanes of `op_a` fill the low half of `res` in lane order, and those of `op_b` fill the high half. With `lane_sz` 0 or 3 the result is zero.
- R12: Opcodes 19 to 31 give a zero result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation request for this cycle |
| opcode | input | 5 | Operation code (see requirements) |
| lane_sz | input | 2 | Lane width select |
| shamt | input | 6 | Shift count for the shift opcodes |
| op_a | input | 64 | First operand |
| op_b | input | 64 | Second operand |
| res | output | 64 | Registered result |
| res_valid | output | 1 | Result updated in the previous edge |

## Verification
On every cycle, the assertions check the valid and hold timing and the zero result of unused opcodes. They also check algebraic identities that need no arithmetic model: a zero unsigned difference of equal operands, a clamped unsigned sum of an all-ones operand, a zero XOR of equal operands, an all-ones equality of equal operands, mask-shaped compare outputs, and a zero wide logical left shift. Only the bench's directed vectors can show clamping at the exact signed boundaries, lane isolation of carries, and shift fill patterns. The same holds for product halves, the multiply-accumulate sums and the placement and clamping of the pack result.

// File: rtl/simd_sat_alu.sv
module simd_sat_alu #(
  parameter int WORD_W = 64,
  parameter int OPC_W  = 5,
  parameter int SH_W   = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [OPC_W-1:0]  opcode,
  input  logic [1:0]        lane_sz,
  input  logic [SH_W-1:0]   shamt,
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  output logic [WORD_W-1:0] res,
  output logic              res_valid
);
  localparam logic [OPC_W-1:0] OP_ADD  = 5'd0,  OP_ADDS = 5'd1,  OP_ADDU = 5'd2;
  localparam logic [OPC_W-1:0] OP_SUB  = 5'd3,  OP_SUBS = 5'd4,  OP_SUBU = 5'd5;
  localparam logic [OPC_W-1:0] OP_AND  = 5'd6,  OP_ANDN = 5'd7,  OP_OR   = 5'd8;
  localparam logic [OPC_W-1:0] OP_XOR  = 5'd9,  OP_SLL  = 5'd10, OP_SRL  = 5'd11;
  localparam logic [OPC_W-1:0] OP_SRA  = 5'd12, OP_CEQ  = 5'd13, OP_CGT  = 5'd14;
  localparam logic [OPC_W-1:0] OP_MULL = 5'd15, OP_MULH = 5'd16, OP_MADD = 5'd17;
  localparam logic [OPC_W-1:0] OP_PACK = 5'd18;
  localparam int NH = WORD_W / 16;
  localparam int NW = WORD_W / 32;
  localparam int HALF = WORD_W / 2;

  function automatic logic [7:0] clamp8(input logic [15:0] v);
    if (!v[15] && v[14:7] != 8'h00)      return 8'h7F;
    else if (v[15] && v[14:7] != 8'hFF)  return 8'h80;
    else                                 return v[7:0];
  endfunction

  function automatic logic [15:0] clamp16(input logic [31:0] v);
    if (!v[31] && v[30:15] != 16'h0000)      return 16'h7FFF;
    else if (v[31] && v[30:15] != 16'hFFFF)  return 16'h8000;
    else                                     return v[15:0];
  endfunction

  for (genvar g = 0; g < 3; g++) begin : g_sz
    localparam int LW = 8 << g;
    localparam int NL = WORD_W / LW;
    logic [WORD_W-1:0] res_g;
    for (genvar i = 0; i < NL; i++) begin : g_ln
      logic [LW-1:0] a, b, r, smax, smin;
      logic [LW:0]   s, d;
      logic          ovf_add, ovf_sub;
      assign a = op_a[i*LW +: LW];
      assign b = op_b[i*LW +: LW];
      assign s = {1'b0, a} + {1'b0, b};
      assign d = {1'b0, a} - {1'b0, b};
      assign smax = {1'b0, {(LW-1){1'b1}}};
      assign smin = {1'b1, {(LW-1){1'b0}}};
      assign ovf_add = (a[LW-1] == b[LW-1]) && (s[LW-1] != a[LW-1]);
      assign ovf_sub = (a[LW-1] != b[LW-1]) && (d[LW-1] != a[LW-1]);
      always_comb begin
        case (opcode)
          OP_ADD:  r = s[LW-1:0];
          OP_ADDS: r = ovf_add ? (a[LW-1] ? smin : smax) : s[LW-1:0];
          OP_ADDU: r = s[LW] ? {LW{1'b1}} : s[LW-1:0];
          OP_SUB:  r = d[LW-1:0];
          OP_SUBS: r = ovf_sub ? (a[LW-1] ? smin : smax) : d[LW-1:0];
          OP_SUBU: r = d[LW] ? {LW{1'b0}} : d[LW-1:0];
          OP_SLL:  r = a << shamt;
          OP_SRL:  r = a >> shamt;
          OP_SRA:  r = $signed(a) >>> shamt;
          OP_CEQ:  r = {LW{a == b}};
          OP_CGT:  r = {LW{$signed(a) > $signed(b)}};
          default: r = '0;
        endcase
      end
      assign res_g[i*LW +: LW] = r;
    end
  end

  logic [WORD_W-1:0] mul_lo, mul_hi, madd, pk8, pk16, nxt;

  for (genvar j = 0; j < NH; j++) begin : g_mul
    logic signed [31:0] p;
    assign p = $signed(op_a[16*j +: 16]) * $signed(op_b[16*j +: 16]);
    assign mul_lo[16*j +: 16] = p[15:0];
    assign mul_hi[16*j +: 16] = p[31:16];
    assign pk8[8*j +: 8]        = clamp8(op_a[16*j +: 16]);
    assign pk8[HALF+8*j +: 8]   = clamp8(op_b[16*j +: 16]);
  end

  for (genvar m = 0; m < NW; m++) begin : g_wide
    assign madd[32*m +: 32]      = g_mul[2*m].p + g_mul[2*m+1].p;
    assign pk16[16*m +: 16]      = clamp16(op_a[32*m +: 32]);
    assign pk16[HALF+16*m +: 16] = clamp16(op_b[32*m +: 32]);
  end

  always_comb begin
    case (opcode)
      OP_AND:  nxt = op_a & op_b;
      OP_ANDN: nxt = ~op_a & op_b;
      OP_OR:   nxt = op_a | op_b;
      OP_XOR:  nxt = op_a ^ op_b;
      OP_MULL: nxt = mul_lo;
      OP_MULH: nxt = mul_hi;
      OP_MADD: nxt = madd;
      OP_PACK: nxt = (lane_sz == 2'd1) ? pk8 : (lane_sz == 2'd2) ? pk16 : '0;
      default: begin
        case (lane_sz)
          2'd0:    nxt = g_sz[0].res_g;
          2'd1:    nxt = g_sz[1].res_g;
          default: nxt = g_sz[2].res_g;
        endcase
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res       <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= in_valid;
      if (in_valid) res <= nxt;
    end
  end
endmodule

module simd_sat_alu_chk #(
  parameter int WORD_W = 64,
  parameter int OPC_W  = 5,
  parameter int SH_W   = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [OPC_W-1:0]  opcode,
  input logic [1:0]        lane_sz,
  input logic [SH_W-1:0]   shamt,
  input logic [WORD_W-1:0] op_a,
  input logic [WORD_W-1:0] op_b,
  input logic [WORD_W-1:0] res,
  input logic              res_valid
);
  function automatic logic is_byte_mask(input logic [WORD_W-1:0] v);
    for (int k = 0; k < WORD_W/8; k++)
      if (v[8*k +: 8] != 8'h00 && v[8*k +: 8] != 8'hFF) return 1'b0;
    return 1'b1;
  endfunction

  assert_valid_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> res_valid);
  assert_valid_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !res_valid);
  assert_hold_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(res));
  assert_usub_equal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 5'd5 && op_a == op_b) |=> res == '0);
  assert_uadd_ones_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 5'd2 && op_a == '1) |=> res == '1);
  assert_xor_equal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 5'd9 && op_a == op_b) |=> res == '0);
  assert_sll_wide_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 5'd10 && shamt >= 6'd32) |=> res == '0);
  assert_ceq_equal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode == 5'd13 && op_a == op_b) |=> res == '1);
  assert_cmp_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (opcode == 5'd13 || opcode == 5'd14)) |=> is_byte_mask(res));
  assert_unused_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && opcode > 5'd18) |=> res == '0);
endmodule

bind simd_sat_alu simd_sat_alu_chk #(.WORD_W(WORD_W), .OPC_W(OPC_W), .SH_W(SH_W)) chk_i (.*);

// File: tb/simd_sat_alu_tb.sv
module simd_sat_alu_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [4:0]  opcode = '0;
  logic [1:0]  lane_sz = '0;
  logic [5:0]  shamt = '0;
  logic [63:0] op_a = '0, op_b = '0;
  logic [63:0] res;
  logic        res_valid;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  simd_sat_alu dut_i (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .lane_sz(lane_sz), .shamt(shamt), .op_a(op_a), .op_b(op_b), .res(res),
    .res_valid(res_valid));

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic run_op(input string req, input logic [4:0] op, input logic [1:0] sz,
                        input logic [5:0] sh, input logic [63:0] a, input logic [63:0] b,
                        input logic [63:0] exp);
    @(negedge clk);
    in_valid = 1'b1; opcode = op; lane_sz = sz; shamt = sh; op_a = a; op_b = b;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, res, exp);
    check(req, {63'd0, res_valid}, 64'd1);
  endtask

  task automatic t_reset_r1;
    repeat (3) @(negedge clk);
    check("R1 reset res", res, 64'd0);
    check("R1 reset valid", {63'd0, res_valid}, 64'd0);
    rst_n = 1'b1;
  endtask

  task automatic t_hold_r1;
    run_op("R1 load", 5'd0, 2'd0, 6'd0, 64'h0000_0000_0000_0011, 64'h0000_0000_0000_0022,
           64'h0000_0000_0000_0033);
    opcode = 5'd9; op_a = 64'hDEAD_BEEF_0000_0000; op_b = 64'h1;
    @(negedge clk);
    check("R1 hold res", res, 64'h0000_0000_0000_0033);
    check("R1 hold valid", {63'd0, res_valid}, 64'd0);
  endtask

  task automatic t_wrap_r2;
    run_op("R2 add8", 5'd0, 2'd0, 6'd0, 64'h01FF_7F80_0000_00FF, 64'h0101_0180_0000_0001,
           64'h0200_8000_0000_0000);
    run_op("R2 add16", 5'd0, 2'd1, 6'd0, 64'h0000_0000_FFFF_0001, 64'h0000_0000_0001_0001,
           64'h0000_0000_0000_0002);
    run_op("R2 sub32", 5'd3, 2'd2, 6'd0, 64'h0, 64'h1, 64'h0000_0000_FFFF_FFFF);
    run_op("R2 sub32 sz3", 5'd3, 2'd3, 6'd0, 64'h0, 64'h1, 64'h0000_0000_FFFF_FFFF);
  endtask

  task automatic t_ssat_r3;
    run_op("R3 adds8", 5'd1, 2'd0, 6'd0, 64'h7F80_10F0_0000_0000, 64'h01FF_1010_0000_0000,
           64'h7F80_2000_0000_0000);
    run_op("R3 subs16", 5'd4, 2'd1, 6'd0, 64'h8000_7FFF_0005_0000, 64'h0001_FFFF_0007_0000,
           64'h8000_7FFF_FFFE_0000);
  endtask

  task automatic t_usat_r4;
    run_op("R4 addu32", 5'd2, 2'd2, 6'd0, 64'hFFFF_FFF0_0000_0001, 64'h0000_0020_0000_0002,
           64'hFFFF_FFFF_0000_0003);
    run_op("R4 subu8", 5'd5, 2'd0, 6'd0, 64'h0510_0000_0000_00FF, 64'h0605_0000_0000_0001,
           64'h000B_0000_0000_00FE);
  endtask

  task automatic t_logic_r5;
    logic [63:0] a = 64'hF0F0_F0F0_F0F0_F0F0, b = 64'hFF00_FF00_FF00_FF00;
    run_op("R5 and", 5'd6, 2'd0, 6'd0, a, b, 64'hF000_F000_F000_F000);
    run_op("R5 andn", 5'd7, 2'd1, 6'd0, a, b, 64'h0F00_0F00_0F00_0F00);
    run_op("R5 or", 5'd8, 2'd2, 6'd0, a, b, 64'hFFF0_FFF0_FFF0_FFF0);
    run_op("R5 xor", 5'd9, 2'd0, 6'd0, a, b, 64'h0FF0_0FF0_0FF0_0FF0);
  endtask

  task automatic t_shift_r6;
    run_op("R6 sll16", 5'd10, 2'd1, 6'd4, 64'h1234_8001_00FF_F00F, 64'h0,
           64'h2340_0010_0FF0_00F0);
    run_op("R6 srl8", 5'd11, 2'd0, 6'd1, 64'h80FF_0102_0000_0000, 64'h0,
           64'h407F_0001_0000_0000);
    run_op("R6 sra32", 5'd12, 2'd2, 6'd4, 64'h8000_0000_7000_0000, 64'h0,
           64'hF800_0000_0700_0000);
  endtask

  task automatic t_wide_shift_r7;
    run_op("R7 sll8 by8", 5'd10, 2'd0, 6'd8, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0);
    run_op("R7 sra16 by16", 5'd12, 2'd1, 6'd16, 64'h8000_7FFF_FFFF_0001, 64'h0,
           64'hFFFF_0000_FFFF_0000);
    run_op("R7 srl32 by32", 5'd11, 2'd2, 6'd32, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 64'h0);
    run_op("R7 sra32 by31", 5'd12, 2'd2, 6'd31, 64'h8000_0000_4000_0000, 64'h0,
           64'hFFFF_FFFF_0000_0000);
  endtask

  task automatic t_cmp_r8;
    run_op("R8 ceq8", 5'd13, 2'd0, 6'd0, 64'h0102_0304_0506_0708, 64'h0100_0304_0000_0708,
           64'hFF00_FFFF_0000_FFFF);
    run_op("R8 cgt16", 5'd14, 2'd1, 6'd0, 64'h0001_8000_7FFF_0005, 64'hFFFF_0000_8000_0005,
           64'hFFFF_0000_FFFF_0000);
  endtask

  task automatic t_mul_r9;
    run_op("R9 mullo", 5'd15, 2'd0, 6'd0, 64'h0003_FFFF_0100_7FFF, 64'h0004_0002_0100_0002,
           64'h000C_FFFE_0000_FFFE);
    run_op("R9 mulhi", 5'd16, 2'd2, 6'd0, 64'h0003_FFFF_0100_7FFF, 64'h0004_0002_0100_0002,
           64'h0000_FFFF_0001_0000);
  endtask

  task automatic t_madd_r10;
    run_op("R10 madd", 5'd17, 2'd0, 6'd0, 64'h0002_0003_8000_8000, 64'h0004_FFFF_8000_8000,
           64'h0000_0005_8000_0000);
  endtask

  task automatic t_pack_r11;
    run_op("R11 pack16to8", 5'd18, 2'd1, 6'd0, 64'h0100_FF00_007F_FFFF,
           64'h0000_0001_FF80_FF7F, 64'h0001_8080_7F80_7FFF);
    run_op("R11 pack32to16", 5'd18, 2'd2, 6'd0, 64'h0001_0000_FFFF_8000,
           64'h0000_1234_FFFF_0000, 64'h1234_8000_7FFF_8000);
    run_op("R11 pack sz0", 5'd18, 2'd0, 6'd0, 64'h0001_0002_0003_0004,
           64'h0005_0006_0007_0008, 64'h0);
  endtask

  task automatic t_unused_r12;
    run_op("R12 op20", 5'd20, 2'd1, 6'd3, 64'h1234_5678_9ABC_DEF0, 64'hFFFF_0000_FFFF_0000,
           64'h0);
  endtask

  initial begin
    t_reset_r1();
    t_hold_r1();
    t_wrap_r2();
    t_ssat_r3();
    t_usat_r4();
    t_logic_r5();
    t_shift_r6();
    t_wide_shift_r7();
    t_cmp_r8();
    t_mul_r9();
    t_madd_r10();
    t_pack_r11();
    t_unused_r12();
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule